// File: doc/BRIEF.md
# Selectable Integer Relational Comparator

This block compares two operands of the same width and returns one bit. A 4-bit selector chooses the relation to test. The relations are equality, inequality, and the four ordering tests in both unsigned and two's-complement signed form. The block has no clock and no state, so the result follows the inputs within one combinational path. It is meant for datapaths that need a condition flag chosen at run time, such as branch resolution or a compare-and-select stage.

The equality and inequality results are reductions over the bitwise difference of the operands. The ordering results come from a running decision that moves from the least significant bit toward the most significant bit. At each position the running value is replaced when the operands differ there and is kept when they agree. The running value starts at 1 for the "or equal" forms and at 0 for the strict forms. The signed forms run the same decision over every bit except the sign bit. When the two sign bits differ, the sign bits alone give the answer. When they match, the result from the lower bits is used unchanged.

Top module: `int_cmp_sel`

## Requirements
- R1: With selector code 0, the result is 1 exactly when every bit of `op_a` equals the matching bit of `op_b`.
- R2: With selector code 1, the result is 1 exactly when at least one bit position differs between the operands.
- R3: Codes 2 and 3 give unsigned `op_a < op_b` and unsigned `op_a <= op_b`.
- R4: Codes 4 and 5 give unsigned `op_a > op_b` and unsigned `op_a >= op_b`.
- R5: Codes 6 and 7 give two's-complement `op_a < op_b` and `op_a <= op_b`. The sign bit is bit WIDTH-1.
- R6: Codes 8 and 9 give two's-complement `op_a > op_b` and `op_a >= op_b`.
- R7: Selector codes 10 to 15 always give a result of 0, whatever the operands are.
- R8: The result is purely combinational. A change on any input shows up on `result` with no clock edge.
- R9: When the operands are equal, codes 0, 3, 5, 7 and 9 give 1, and codes 1, 2, 4, 6 and 8 give 0.
- R10: When the sign bits of the operands differ, the signed less-than forms return the sign bit of `op_a` and the signed greater-than forms return the sign bit of `op_b`. The lower bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Left operand |
| op_b | input | WIDTH | Right operand |
| pred_sel | input | 4 | Relation code: 0 eq, 1 ne, 2 ult, 3 ule, 4 ugt, 5 uge, 6 slt, 7 sle, 8 sgt, 9 sge, others unused |
| result | output | 1 | Outcome of the selected relation |

## Verification
At 4-bit width, every operand pair is applied under every one of the 16 codes. This covers each carry-free ordering case, every sign combination, and the unused codes. At 16-bit width, random operands are mixed with directed pairs:
- Equal operands separate strict from inclusive forms.
- Operands that differ only in the least significant bit check that the running decision reaches the top.
- Operands with opposite sign bits and mirrored lower bits show that the sign-split path overrides the lower-bit decision.

Changing an input with no clock edge and reading the result at once shows that the output is combinational.

// File: rtl/int_cmp_sel.sv
module int_cmp_sel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       pred_sel,
  output logic             result
);

  localparam int MSB  = WIDTH - 1;
  localparam int NCH  = 4;

  logic [WIDTH-1:0] diff;
  logic             all_same;
  logic             any_diff;
  logic             sign_split;
  logic [NCH-1:0]   uns;
  logic [NCH-1:0]   sgn;

  assign diff       = op_a ^ op_b;
  assign all_same   = ~|diff;
  assign any_diff   = |diff;
  assign sign_split = diff[MSB];

  // chain 0: lt, 1: le, 2: gt, 3: ge
  for (genvar c = 0; c < NCH; c++) begin : g_chain
    localparam bit LESS = (c < 2);
    localparam bit INCL = (c % 2) == 1;
    logic low_r;
    logic full_r;

    always_comb begin
      logic r;
      logic w;
      r = INCL;
      for (int i = 0; i < MSB; i++) begin
        w = LESS ? (~op_a[i] & op_b[i]) : (op_a[i] & ~op_b[i]);
        r = w | (~diff[i] & r);
      end
      low_r = r;
      w = LESS ? (~op_a[MSB] & op_b[MSB]) : (op_a[MSB] & ~op_b[MSB]);
      full_r = w | (~diff[MSB] & r);
    end

    assign uns[c] = full_r;
    assign sgn[c] = sign_split ? (LESS ? op_a[MSB] : op_b[MSB]) : low_r;
  end

  always_comb begin
    case (pred_sel)
      4'd0:    result = all_same;
      4'd1:    result = any_diff;
      4'd2:    result = uns[0];
      4'd3:    result = uns[1];
      4'd4:    result = uns[2];
      4'd5:    result = uns[3];
      4'd6:    result = sgn[0];
      4'd7:    result = sgn[1];
      4'd8:    result = sgn[2];
      4'd9:    result = sgn[3];
      default: result = 1'b0;
    endcase
  end

  always_comb begin
    a_r2_eq_ne_exclusive: assert (all_same != any_diff);
    a_r3_strict_implies_incl: assert (!uns[0] || uns[1]);
    a_r4_lt_gt_disjoint: assert (!(uns[0] && uns[2]));
    a_r7_unused_zero: assert (pred_sel <= 4'd9 || !result);
    a_r9_equal_ops: assert (!all_same || (uns[1] && uns[3] && !uns[0] && !uns[2]));
    a_r10_sign_split: assert (!(sign_split && pred_sel == 4'd6) || result == op_a[MSB]);
  end

endmodule

// File: tb/int_cmp_sel_bench.sv
`timescale 1ns/1ps
module int_cmp_sel_bench;
  localparam int CLK_P = 10;
  localparam int WN = 4;
  localparam int WW = 16;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [WN-1:0] na, nb;
  logic [WW-1:0] wa, wb;
  logic [3:0]    nsel, wsel;
  logic          nres, wres;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  int_cmp_sel #(.WIDTH(WN)) u_int_cmp_sel (
    .op_a(na), .op_b(nb), .pred_sel(nsel), .result(nres));
  int_cmp_sel #(.WIDTH(WW)) u_int_cmp_sel_wide (
    .op_a(wa), .op_b(wb), .pred_sel(wsel), .result(wres));

  function automatic bit model(input logic [31:0] a, input logic [31:0] b,
                               input int w, input logic [3:0] code);
    logic [31:0] ua, ub;
    logic signed [31:0] sa, sb;
    ua = (a << (32 - w)) >> (32 - w);
    ub = (b << (32 - w)) >> (32 - w);
    sa = $signed(a << (32 - w)) >>> (32 - w);
    sb = $signed(b << (32 - w)) >>> (32 - w);
    case (code)
      4'd0: return ua == ub;
      4'd1: return ua != ub;
      4'd2: return ua <  ub;
      4'd3: return ua <= ub;
      4'd4: return ua >  ub;
      4'd5: return ua >= ub;
      4'd6: return sa <  sb;
      4'd7: return sa <= sb;
      4'd8: return sa >  sb;
      4'd9: return sa >= sb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] code);
    case (code)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic judge(input string req, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wide_check(input logic [WW-1:0] a, input logic [WW-1:0] b,
                            input logic [3:0] code, input string req);
    wa = a; wb = b; wsel = code;
    #1;
    judge(req, wres, model(32'(a), 32'(b), WW, code));
  endtask

  initial begin
    na = '0; nb = '0; nsel = 4'd0;
    wa = '0; wb = '0; wsel = 4'd0;
    #(CLK_P/2);
    judge("R1", nres, 1'b1);
    judge("R9", wres, 1'b1);

    void'($urandom(32'd1234));

    // exhaustive narrow sweep: R1 R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          na = WN'(a); nb = WN'(b); nsel = 4'(c);
          #1;
          judge(tag(4'(c)), nres, model(32'(a), 32'(b), WN, 4'(c)));
        end

    // R9 equal operands on the wide instance
    for (int c = 0; c < 10; c++) begin
      wide_check(16'hA5C3, 16'hA5C3, 4'(c), "R9");
      wide_check(16'h8000, 16'h8000, 4'(c), "R9");
    end

    // LSB-only difference
    for (int c = 2; c < 10; c++) begin
      wide_check(16'h7FFE, 16'h7FFF, 4'(c), tag(4'(c)));
      wide_check(16'hFFFF, 16'hFFFE, 4'(c), tag(4'(c)));
    end

    // R10 sign split with mirrored lower bits
    for (int c = 6; c < 10; c++) begin
      wide_check(16'h8000, 16'h7FFF, 4'(c), "R10");
      wide_check(16'h7FFF, 16'h8000, 4'(c), "R10");
      wide_check(16'hFFFF, 16'h0000, 4'(c), "R10");
      wide_check(16'h0001, 16'hFFFE, 4'(c), "R10");
    end

    // R7 unused codes with varied operands
    for (int c = 10; c < 16; c++) begin
      wide_check(16'h1234, 16'h1234, 4'(c), "R7");
      wide_check(16'h0000, 16'hFFFF, 4'(c), "R7");
    end

    // R8 combinational response: input change without a clock edge
    wa = 16'h0010; wb = 16'h0020; wsel = 4'd2;
    #1;
    judge("R8", wres, 1'b1);
    wb = 16'h0008;
    #1;
    judge("R8", wres, 1'b0);
    wsel = 4'd4;
    #1;
    judge("R8", wres, 1'b1);

    // random wide sweep
    for (int k = 0; k < 3000; k++) begin
      logic [WW-1:0] ra, rb;
      logic [3:0] rc;
      ra = WW'($urandom);
      rb = (k % 7 == 0) ? ra ^ WW'(1 << ($urandom % WW)) : WW'($urandom);
      rc = 4'($urandom % 16);
      wide_check(ra, rb, rc, tag(rc));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule